// File: doc/BRIEF.md
# Serial SAR ADC cycle sequencer

This block is the digital controller of a serial sampling converter. A host drives a serial clock, an active-low chip select and, optionally, a frame-sync strobe. The block detects the edges of these pins on its own system clock and counts falling serial-clock edges from the start of each cycle. From that count it produces the sample window, the conversion window and the conversion-clock ticks, and it returns to power-down when the conversion ends.

While a cycle runs, the block shifts out, MSB first, the 16-bit frame that holds the result of the previous conversion. The frame is driven on a data pin that has a separate output enable. It also keeps a two-input channel select. A short chip-select pulse sends the channel select back to input 0, and a full-length cycle moves it to the other input. The analog converter is outside the block. At the end of each conversion the block captures a 12-bit result from a behavioural stub.

Top module: `sar_seq_top`

## Requirements
- R1: `sample_o` is high from the 4th falling serial-clock edge after cycle start until the 16th. This is a window of 12 serial-clock periods that starts in the 5th period.
- R2: `convert_o` is high from the 16th falling edge until the 44th, which is 28 serial-clock periods. The conversion completes on the 44th falling edge.
- R3: `conv_tick_o` pulses for one clock on falling edges 18, 20, …, 44 of an active cycle. This gives 14 conversion-clock ticks at half the serial-clock rate.
- R4: The frame is 16 bits, MSB first. Bits 15..4 hold the 12-bit unsigned result and bits 3..0 are zero. The MSB appears on `sdo` at wake-up, and `sdo` advances on each rising serial-clock edge that comes after the first falling edge.
- R5: `sdo_oe` rises at wake-up while chip select is low. It falls on the 16th falling edge, and one clock after chip select is seen high.
- R6: If chip select rises before the 44th falling edge, the cycle is aborted and power-down is set. The next frame is then all zeros. A frame is also all zeros when no conversion has completed since reset.
- R7: `pd_o` is 1 after reset. It clears on wake-up or cycle start and sets on the 44th falling edge.
- R8: `chan_o` is 0 after reset. When chip select rises after 4 to 7 falling edges, `chan_o` becomes 0. After 8 or more falling edges it toggles, and after fewer than 4 it is unchanged.
- R9: With `fs_mode`=1, a rising edge on `fs` wakes the block and presents the frame. A falling edge on `fs` while chip select is low starts the cycle. A chip-select fall alone does not start the sample window.
- R10: A frame carries the value on `conv_data` at the 44th falling edge of the previous cycle. Later changes to `conv_data` do not affect it.
- R11: The edge counter saturates, so a chip-select low time far beyond 44 edges still completes the conversion normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Host serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame-sync strobe |
| fs_mode | input | 1 | 1: cycle started by fs; 0: by chip select |
| conv_data | input | 12 | Result from the converter stub |
| sdo | output | 1 | Serial data, valid when sdo_oe is 1 |
| sdo_oe | output | 1 | Output enable for sdo |
| sample_o | output | 1 | Sample window strobe |
| convert_o | output | 1 | Conversion window strobe |
| conv_tick_o | output | 1 | Conversion-clock tick pulse |
| pd_o | output | 1 | Power-down flag |
| chan_o | output | 1 | Selected input channel |

## Verification
The bench targets the channel thresholds with chip-select pulses of 2, 5, 45, 50 and 60 edges. A design with an off-by-one threshold would toggle where it should reset, or reset where it should leave the channel alone. Aborted cycles are followed by full cycles to confirm that the next frame is zeros. A design that kept the stale result would show the old code there. The bench also changes `conv_data` after a conversion completes. A design that loaded the shift register late would shift out the new value. In frame-sync mode a chip-select fall followed by edges must not open a sample window; a design that mixed up the two start sources would sample early.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Edge events of the host pins, one clock wide.
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_fall;
        logic cs_rise;
        logic fs_rise;
        logic fs_fall;
    } pin_edges_t;
endpackage

// File: rtl/sar_seq_edges.sv
module sar_seq_edges
    import sar_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       fs,
    output pin_edges_t ev
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic fs;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d.sclk   = sclk;
        pins_d.cs_n   = cs_n;
        pins_d.fs     = fs;
        ev.sclk_rise  = sclk & ~pins_q.sclk;
        ev.sclk_fall  = ~sclk & pins_q.sclk;
        ev.cs_fall    = ~cs_n & pins_q.cs_n;
        ev.cs_rise    = cs_n & ~pins_q.cs_n;
        ev.fs_rise    = fs & ~pins_q.fs;
        ev.fs_fall    = ~fs & pins_q.fs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '{sclk: 1'b0, cs_n: 1'b1, fs: 1'b0};
        else        pins_q <= pins_d;
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int RES_W      = 12,
    parameter int SMP_START  = 4,
    parameter int CONV_START = 16,
    parameter int CONV_END   = 44,
    parameter int CNT_SAT    = 45,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_mode,
    input  logic             cs_n,
    input  logic             sclk_fall,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             fs_rise,
    input  logic             fs_fall,
    input  logic [RES_W-1:0] conv_data,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic [RES_W-1:0] hold,
    output logic             hold_ok,
    output logic             wake,
    output logic             pd_o,
    output logic             tick_o,
    output logic             sample_o,
    output logic             convert_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CNT_W-1:0] K_SMP = CNT_W'(SMP_START);
    localparam logic [CNT_W-1:0] K_CS  = CNT_W'(CONV_START);
    localparam logic [CNT_W-1:0] K_CE  = CNT_W'(CONV_END);
    localparam logic [CNT_W-1:0] K_SAT = CNT_W'(CNT_SAT);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             pd;
        logic [RES_W-1:0] hold;
        logic             hold_ok;
        logic             tick;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic             start;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] rel;

    always_comb begin
        wake  = !st_q.active && (cs_fall || (fs_mode && fs_rise));
        start = !st_q.active && (fs_mode ? (fs_fall && !cs_n) : cs_fall);
        inc   = st_q.cnt + CNT_W'(1);
        rel   = inc - K_CS;

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.pd     = 1'b0;
        end else if (cs_rise && st_q.active) begin
            // early release: the conversion is lost
            st_d.active  = 1'b0;
            st_d.pd      = 1'b1;
            st_d.hold_ok = 1'b0;
        end else if (sclk_fall && st_q.cnt != K_SAT) begin
            st_d.cnt = inc;
            if (st_q.active) begin
                if (inc == K_CE) begin
                    st_d.active  = 1'b0;
                    st_d.pd      = 1'b1;
                    st_d.hold    = conv_data;
                    st_d.hold_ok = 1'b1;
                end
                if (inc > K_CS && inc <= K_CE && !rel[0]) st_d.tick = 1'b1;
            end
        end
        if (wake) st_d.pd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, cnt: K_SAT, pd: 1'b1, hold: '0,
                      hold_ok: 1'b0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign cnt       = st_q.cnt;
    assign hold      = st_q.hold;
    assign hold_ok   = st_q.hold_ok;
    assign pd_o      = st_q.pd;
    assign tick_o    = st_q.tick;
    assign sample_o  = st_q.active && st_q.cnt >= K_SMP && st_q.cnt < K_CS;
    assign convert_o = st_q.active && st_q.cnt >= K_CS && st_q.cnt < K_CE;
endmodule

// File: rtl/sar_seq_shift.sv
module sar_seq_shift #(
    parameter int RES_W   = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wake,
    input  logic             active,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic [CNT_W-1:0] cnt,
    input  logic [RES_W-1:0] hold,
    input  logic             hold_ok,
    output logic             sdo,
    output logic             sdo_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int               PAD  = FRAME_W - RES_W;
    localparam logic [CNT_W-1:0] K_FR = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic               oe;
    } shf_t;

    shf_t               sh_d, sh_q;
    logic [FRAME_W-1:0] load;
    logic [CNT_W-1:0]   inc;

    always_comb begin
        load = hold_ok ? {hold, {PAD{1'b0}}} : '0;
        inc  = cnt + CNT_W'(1);
        sh_d = sh_q;
        if (cs_n) begin
            sh_d.oe = 1'b0;
        end else if (wake) begin
            sh_d.sreg = load;
            sh_d.oe   = 1'b1;
        end else if (active && sclk_fall && inc == K_FR) begin
            sh_d.oe = 1'b0;
        end else if (active && sclk_rise && cnt != '0 && cnt < K_FR) begin
            sh_d.sreg = {sh_q.sreg[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '{sreg: '0, oe: 1'b0};
        else        sh_q <= sh_d;
    end

    assign sdo    = sh_q.sreg[FRAME_W-1];
    assign sdo_oe = sh_q.oe;
endmodule

// File: rtl/sar_seq_chan.sv
module sar_seq_chan #(
    parameter int CNT_W   = 6,
    parameter int RST_MIN = 4,
    parameter int RST_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] cnt,
    output logic             chan
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CNT_W-1:0] K_MIN = CNT_W'(RST_MIN);
    localparam logic [CNT_W-1:0] K_MAX = CNT_W'(RST_MAX);

    logic chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (cs_rise) begin
            if (cnt >= K_MIN && cnt <= K_MAX) chan_d = 1'b0;
            else if (cnt > K_MAX)             chan_d = ~chan_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= 1'b0;
        else        chan_q <= chan_d;
    end

    assign chan = chan_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int FRAME_W   = 16,
    parameter int SMP_START = 4,
    parameter int SMP_LEN   = 12,
    parameter int CONV_LEN  = 28,
    parameter int RST_MIN   = 4,
    parameter int RST_MAX   = 7,
    parameter bit TWO_CHAN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             fs_mode,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sample_o,
    output logic             convert_o,
    output logic             conv_tick_o,
    output logic             pd_o,
    output logic             chan_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CONV_START = SMP_START + SMP_LEN;
    localparam int CONV_END   = CONV_START + CONV_LEN;
    localparam int CNT_SAT    = CONV_END + 1;
    localparam int CNT_W      = $clog2(CNT_SAT + 1);

    pin_edges_t       ev;
    logic             active;
    logic             wake;
    logic             hold_ok;
    logic [CNT_W-1:0] cnt;
    logic [RES_W-1:0] hold;

    sar_seq_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .fs    (fs),
        .ev    (ev)
    );

    sar_seq_ctrl #(
        .RES_W      (RES_W),
        .SMP_START  (SMP_START),
        .CONV_START (CONV_START),
        .CONV_END   (CONV_END),
        .CNT_SAT    (CNT_SAT),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_mode   (fs_mode),
        .cs_n      (cs_n),
        .sclk_fall (ev.sclk_fall),
        .cs_fall   (ev.cs_fall),
        .cs_rise   (ev.cs_rise),
        .fs_rise   (ev.fs_rise),
        .fs_fall   (ev.fs_fall),
        .conv_data (conv_data),
        .active    (active),
        .cnt       (cnt),
        .hold      (hold),
        .hold_ok   (hold_ok),
        .wake      (wake),
        .pd_o      (pd_o),
        .tick_o    (conv_tick_o),
        .sample_o  (sample_o),
        .convert_o (convert_o)
    );

    sar_seq_shift #(
        .RES_W   (RES_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wake      (wake),
        .active    (active),
        .sclk_rise (ev.sclk_rise),
        .sclk_fall (ev.sclk_fall),
        .cnt       (cnt),
        .hold      (hold),
        .hold_ok   (hold_ok),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    generate
        if (TWO_CHAN) begin : g_two_chan
            sar_seq_chan #(
                .CNT_W   (CNT_W),
                .RST_MIN (RST_MIN),
                .RST_MAX (RST_MAX)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .cs_rise (ev.cs_rise),
                .cnt     (cnt),
                .chan    (chan_o)
            );
        end else begin : g_one_chan
            assign chan_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo_oe,
    input logic sample_o,
    input logic convert_o,
    input logic conv_tick_o,
    input logic pd_o,
    input logic chan_o
);
    timeunit 1ns;
    timeprecision 1ps;

    a_r5_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    a_r2_convert_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_o) |-> $past(sample_o));

    a_r7_awake_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o || convert_o) |-> !pd_o);

    a_r3_tick_inside_conversion: assert property (@(posedge clk) disable iff (!rst_n)
        conv_tick_o |-> $past(convert_o));

    a_r6_pd_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_o) |-> ($past(convert_o) || $past(cs_n)));

    a_r8_chan_moves_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_o) |-> $past(cs_n));
endmodule

bind sar_seq_top sar_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sdo_oe      (sdo_oe),
    .sample_o    (sample_o),
    .convert_o   (convert_o),
    .conv_tick_o (conv_tick_o),
    .pd_o        (pd_o),
    .chan_o      (chan_o)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        fs = 1'b0;
    logic        fs_mode = 1'b0;
    logic [11:0] conv_data = 12'h000;
    logic        sdo, sdo_oe, sample_o, convert_o, conv_tick_o, pd_o, chan_o;

    int n_chk = 0;
    int n_fail = 0;
    int tick_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar_seq_top dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .fs(fs),
        .fs_mode(fs_mode), .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe),
        .sample_o(sample_o), .convert_o(convert_o), .conv_tick_o(conv_tick_o),
        .pd_o(pd_o), .chan_o(chan_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        pv_sclk, pv_cs, pv_fs;
    bit          m_act, m_pd, m_hok, m_tick, m_oe, m_chan;
    int          m_cnt;
    logic [11:0] m_hold;
    logic [15:0] m_sreg;

    always @(posedge clk) begin : model
        bit sr, sf, cf, cr, fr, ff, wk, st, o_act, o_hok;
        int o_cnt;
        logic [11:0] o_hold;
        if (!rst_n) begin
            pv_sclk = 1'b0; pv_cs = 1'b1; pv_fs = 1'b0;
            m_act = 0; m_cnt = 45; m_pd = 1; m_hok = 0; m_hold = '0;
            m_tick = 0; m_oe = 0; m_chan = 0; m_sreg = '0;
        end else begin
            sr = sclk && !pv_sclk;  sf = !sclk && pv_sclk;
            cf = !cs_n && pv_cs;    cr = cs_n && !pv_cs;
            fr = fs && !pv_fs;      ff = !fs && pv_fs;
            o_cnt = m_cnt; o_act = m_act; o_hok = m_hok; o_hold = m_hold;
            wk = !o_act && (cf || (fs_mode && fr));
            st = !o_act && (fs_mode ? (ff && !cs_n) : cf);
            m_tick = 0;
            if (st) begin
                m_act = 1; m_cnt = 0; m_pd = 0;
            end else if (cr && o_act) begin
                m_act = 0; m_pd = 1; m_hok = 0;
            end else if (sf && o_cnt < 45) begin
                m_cnt = o_cnt + 1;
                if (o_act && m_cnt == 44) begin
                    m_act = 0; m_pd = 1; m_hold = conv_data; m_hok = 1;
                end
                if (o_act && m_cnt > 16 && m_cnt <= 44 && (m_cnt % 2 == 0)) m_tick = 1;
            end
            if (wk) m_pd = 0;
            if (cs_n) m_oe = 0;
            else if (wk) begin
                m_sreg = o_hok ? {o_hold, 4'h0} : 16'h0000;
                m_oe = 1;
            end else if (o_act && sf && o_cnt + 1 == 16) m_oe = 0;
            else if (o_act && sr && o_cnt >= 1 && o_cnt < 16) m_sreg = m_sreg << 1;
            if (cr) begin
                if (o_cnt >= 4 && o_cnt <= 7) m_chan = 0;
                else if (o_cnt >= 8)          m_chan = !m_chan;
            end
            pv_sclk = sclk; pv_cs = cs_n; pv_fs = fs;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(sample_o == (m_act && m_cnt >= 4 && m_cnt < 16), "R1 model sample_o", sample_o, m_act && m_cnt >= 4 && m_cnt < 16);
            chk(convert_o == (m_act && m_cnt >= 16 && m_cnt < 44), "R2 model convert_o", convert_o, m_act && m_cnt >= 16 && m_cnt < 44);
            chk(conv_tick_o == m_tick, "R3 model conv_tick_o", conv_tick_o, m_tick);
            if (m_oe) chk(sdo == m_sreg[15], "R4 model sdo", sdo, m_sreg[15]);
            chk(sdo_oe == m_oe, "R5 model sdo_oe", sdo_oe, m_oe);
            chk(pd_o == m_pd, "R7 model pd_o", pd_o, m_pd);
            chk(chan_o == m_chan, "R8 model chan_o", chan_o, m_chan);
            if (conv_tick_o) tick_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic sclk_pulse(output logic b);
        @(negedge clk) sclk = 1'b1;
        repeat (4) @(negedge clk);
        b = sdo;
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_cycle(input int nf, input logic [11:0] data, output logic [15:0] frame);
        logic b;
        frame = '0;
        conv_data = data;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nf; i++) begin
            sclk_pulse(b);
            if (i < 16) frame[15 - i] = b;
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        sclk_pulse(b);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] f;
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pd_o == 1'b1, "R7 reset pd_o", pd_o, 1);
        chk(sdo_oe == 1'b0, "R5 reset sdo_oe", sdo_oe, 0);
        chk(chan_o == 1'b0, "R8 reset chan_o", chan_o, 0);
        chk(!sample_o && !convert_o, "R1 R2 reset strobes", {sample_o, convert_o}, 0);

        tick_cnt = 0;
        cs_cycle(45, 12'hABC, f);
        chk(f == 16'h0000, "R6 first frame after reset", f, 16'h0000);
        chk(tick_cnt == 14, "R3 tick count", tick_cnt, 14);
        chk(chan_o == 1'b1, "R8 full cycle toggles", chan_o, 1);
        chk(pd_o == 1'b1, "R7 pd after completion", pd_o, 1);

        cs_cycle(45, 12'h123, f);
        chk(f == 16'hABC0, "R4 frame format", f, 16'hABC0);
        chk(chan_o == 1'b0, "R8 second toggle", chan_o, 0);

        conv_data = 12'hFFF;
        repeat (10) @(negedge clk);
        cs_cycle(50, 12'h800, f);
        chk(f == 16'h1230, "R10 previous result kept", f, 16'h1230);

        cs_cycle(5, 12'h777, f);
        chk(chan_o == 1'b0, "R8 short pulse resets channel", chan_o, 0);
        cs_cycle(45, 12'h456, f);
        chk(f == 16'h0000, "R6 frame after abort", f, 16'h0000);
        chk(chan_o == 1'b1, "R8 toggle after reset pulse", chan_o, 1);

        cs_cycle(2, 12'h111, f);
        chk(chan_o == 1'b1, "R8 very short pulse no change", chan_o, 1);

        cs_cycle(60, 12'h5A5, f);
        chk(f == 16'h0000, "R6 frame after second abort", f, 16'h0000);
        chk(chan_o == 1'b0, "R11 long cycle toggles", chan_o, 0);
        cs_cycle(45, 12'h9E1, f);
        chk(f == 16'h5A50, "R11 long cycle result", f, 16'h5A50);

        // frame-sync mode
        fs_mode = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) sclk_pulse(b);
        chk(sample_o == 1'b0, "R9 chip select alone does not start", sample_o, 0);
        @(negedge clk) fs = 1'b1;
        repeat (2) @(negedge clk);
        chk(sdo_oe == 1'b1 && sdo == 1'b1, "R9 fs rise presents MSB", {sdo_oe, sdo}, 2'b11);
        @(negedge clk) fs = 1'b0;
        repeat (2) @(negedge clk);
        tick_cnt = 0;
        f = '0;
        for (int i = 0; i < 45; i++) begin
            sclk_pulse(b);
            if (i < 16) f[15 - i] = b;
        end
        chk(f == 16'h9E10, "R9 fs mode frame", f, 16'h9E10);
        chk(tick_cnt == 14, "R3 fs mode ticks", tick_cnt, 14);
        chk(pd_o == 1'b1, "R7 fs mode power-down", pd_o, 1);
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        sclk_pulse(b);
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule